// File: doc/BRIEF.md
# LED update telegram receiver

This block sits between a byte-wide link from a game controller and the frame memory of a chain of addressable RGB LEDs. The controller sends a telegram as a run of two-byte updates. Each update is an LED index followed by a colour code, and the block turns every update into one write on the frame-memory port. A single reserved byte value, seen where an index is expected, closes the telegram.

When the telegram closes, the block asks the LED chain driver to refresh the chain. It then keeps its ready line low until the driver reports that the refresh is over. The controller watches ready and sends the next telegram only while it is high. Any byte that arrives while ready is low is dropped.

An index beyond the last LED, other than the closing value, makes the block drop the colour byte that follows it and raise an error flag. The flag stays set until reset.

Top module: `led_telegram_rx`

## Requirements
- R1: After reset `rdy` is 1, `addr_err` is 0, and `wr_en` and `refresh_start` are 0.
- R2: When a byte is accepted (`rx_valid` high while `rdy` is high) in the index position and is at most 211, and the next accepted byte is a colour, `wr_en` is high for exactly one cycle. That cycle is the one after the colour byte is accepted, with `wr_addr` equal to the index and `wr_color` equal to the colour.
- R3: An accepted byte equal to 253 in the index position ends the telegram: it causes no write, `refresh_start` is high in the following cycle, and `rdy` is low from that cycle on.
- R4: A byte equal to 253 accepted in the colour position is written as ordinary colour data and does not end the telegram.
- R5: Once low, `rdy` stays low in every cycle where `refresh_done` was low in the cycle before. It is high in the cycle after `refresh_done` is sampled high.
- R6: Bytes presented while `rdy` is low cause no write and no new `refresh_start`. After the refresh, the next accepted byte is taken as an index.
- R7: An accepted index byte above 211 that is not 253 sets `addr_err` in the following cycle, and the colour byte after it produces no write.
- R8: `refresh_start` is high for a single cycle per closed telegram.
- R9: `addr_err`, once set, stays set through later telegrams and refreshes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| rdy | output | 1 | High while a telegram may be sent |
| wr_en | output | 1 | Frame-memory write strobe |
| wr_addr | output | 8 | LED index of the write |
| wr_color | output | 8 | Colour code of the write |
| refresh_start | output | 1 | One-cycle request to refresh the LED chain |
| refresh_done | input | 1 | Chain refresh has finished |
| addr_err | output | 1 | Sticky flag for an out-of-range index |

## Verification
The assertions check several rules on every cycle:
- `refresh_start` is a single-cycle pulse that coincides with low ready.
- Ready is held low until a done, and returns the cycle after it.
- No write appears while busy or with an index past the last LED.
- Every write follows an accepted byte.
- The error flag never clears.

Only the bench scenarios can show which values are written and where. The bench sweeps every legal index and every illegal one. It checks that the closing value is honoured only in the index position, and that bytes dropped during a refresh leave the index/colour pairing intact.

// File: rtl/led_telegram_rx.sv
module led_telegram_rx #(
  parameter int BYTE_W   = 8,
  parameter int LAST_LED = 211,
  parameter int END_CODE = 253
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rdy,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_color,
  output logic              refresh_start,
  input  logic              refresh_done,
  output logic              addr_err
);

  typedef enum logic [1:0] {S_ADDR, S_COLOR, S_BUSY} st_t;

  st_t               st;
  logic [BYTE_W-1:0] addr_q;
  logic              addr_bad;

  wire take     = rx_valid && rdy;
  wire is_end   = rx_byte == BYTE_W'(END_CODE);
  wire past_end = rx_byte > BYTE_W'(LAST_LED);

  assign rdy = (st != S_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_ADDR;
      addr_q        <= '0;
      addr_bad      <= 1'b0;
      wr_en         <= 1'b0;
      wr_addr       <= '0;
      wr_color      <= '0;
      refresh_start <= 1'b0;
      addr_err      <= 1'b0;
    end else begin
      wr_en         <= 1'b0;
      refresh_start <= 1'b0;
      case (st)
        S_ADDR: if (take) begin
          if (is_end) begin
            st            <= S_BUSY;
            refresh_start <= 1'b1;
          end else begin
            addr_q   <= rx_byte;
            addr_bad <= past_end;
            if (past_end) addr_err <= 1'b1;
            st <= S_COLOR;
          end
        end
        S_COLOR: if (take) begin
          st <= S_ADDR;
          if (!addr_bad) begin
            wr_en    <= 1'b1;
            wr_addr  <= addr_q;
            wr_color <= rx_byte;
          end
        end
        S_BUSY: if (refresh_done) st <= S_ADDR;
        default: st <= S_ADDR;
      endcase
    end
  end

endmodule

module led_telegram_rx_chk #(
  parameter int BYTE_W   = 8,
  parameter int LAST_LED = 211
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rdy,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_addr,
  input logic              refresh_start,
  input logic              refresh_done,
  input logic              addr_err
);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start |-> !rdy);

  a_r8_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start |=> !refresh_start);

  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && !refresh_done) |=> !rdy);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && refresh_done) |=> rdy);

  a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rdy);

  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= BYTE_W'(LAST_LED)));

  a_r2_write_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rx_valid));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);

endmodule

bind led_telegram_rx led_telegram_rx_chk #(.BYTE_W(BYTE_W), .LAST_LED(LAST_LED)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rdy(rdy), .wr_en(wr_en),
  .wr_addr(wr_addr), .refresh_start(refresh_start), .refresh_done(refresh_done),
  .addr_err(addr_err)
);

// File: tb/led_telegram_rx_bench.sv
module led_telegram_rx_bench;
  localparam int LAST = 211;
  localparam int ENDC = 253;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0;
  logic       refresh_done = 1'b0;
  logic       rdy, wr_en, refresh_start, addr_err;
  logic [7:0] wr_addr, wr_color;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  led_telegram_rx u_led_telegram_rx (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid), .rdy(rdy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_color(wr_color),
    .refresh_start(refresh_start), .refresh_done(refresh_done), .addr_err(addr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] c, input bit expect_wr, input string req);
    put(a);
    check(wr_en == 1'b0, req, wr_en, 0);
    put(c);
    check(wr_en == expect_wr, req, wr_en, expect_wr);
    if (expect_wr) begin
      check(wr_addr == a, req, wr_addr, a);
      check(wr_color == c, req, wr_color, c);
    end
    @(negedge clk);
    check(wr_en == 1'b0, req, wr_en, 0);
  endtask

  task automatic close_telegram();
    put(8'(ENDC));
    check(refresh_start == 1'b1, "R3", refresh_start, 1);
    check(rdy == 1'b0, "R3", rdy, 0);
    check(wr_en == 1'b0, "R3", wr_en, 0);
    @(negedge clk);
    check(refresh_start == 1'b0, "R8", refresh_start, 0);
  endtask

  task automatic finish_refresh();
    refresh_done = 1'b1;
    @(negedge clk);
    refresh_done = 1'b0;
    check(rdy == 1'b1, "R5", rdy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdy == 1'b1, "R1", rdy, 1);
    check(addr_err == 1'b0, "R1", addr_err, 0);
    check(wr_en == 1'b0, "R1", wr_en, 0);
    check(refresh_start == 1'b0, "R1", refresh_start, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: every legal index with a computed colour
    for (int a = 0; a <= LAST; a++) pair(8'(a), 8'((a * 37 + 5) & 255), 1'b1, "R2");
    // R4: 253 as colour is data, telegram continues
    pair(8'd0, 8'(ENDC), 1'b1, "R4");
    check(rdy == 1'b1, "R4", rdy, 1);
    pair(8'(LAST), 8'(ENDC), 1'b1, "R4");
    check(addr_err == 1'b0, "R2", addr_err, 0);

    close_telegram();
    // R5 / R6: held busy, bytes dropped
    for (int k = 0; k < 6; k++) begin
      put(8'(k == 2 ? ENDC : 5 + k));
      check(wr_en == 1'b0, "R6", wr_en, 0);
      check(refresh_start == 1'b0, "R6", refresh_start, 0);
      check(rdy == 1'b0, "R5", rdy, 0);
    end
    repeat (4) begin
      @(negedge clk);
      check(rdy == 1'b0, "R5", rdy, 0);
    end
    finish_refresh();
    pair(8'd7, 8'd11, 1'b1, "R6");

    // R7: every out-of-range index except the end code
    for (int a = LAST + 1; a <= 255; a++) begin
      if (a != ENDC) begin
        pair(8'(a), 8'h11, 1'b0, "R7");
        check(addr_err == 1'b1, "R7", addr_err, 1);
        check(rdy == 1'b1, "R7", rdy, 1);
      end
    end
    pair(8'd100, 8'd42, 1'b1, "R7");

    // R9: flag survives another telegram and refresh
    close_telegram();
    check(addr_err == 1'b1, "R9", addr_err, 1);
    finish_refresh();
    pair(8'd3, 8'd9, 1'b1, "R9");
    check(addr_err == 1'b1, "R9", addr_err, 1);

    // R3: immediate close with no updates
    close_telegram();
    finish_refresh();

    rst_n = 1'b0;
    @(negedge clk);
    check(addr_err == 1'b0, "R1", addr_err, 0);
    check(rdy == 1'b1, "R1", rdy, 1);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule